// File: doc/BRIEF.md
# Four-Channel Cycle-Steal DMA Engine with Indirect Source

The engine moves words between locations on a shared memory bus on behalf of a processor. Four channels each hold a source address, a destination address, a unit count and a control word. The processor programs them through a plain register-write port. An enabled channel with a nonzero count asks for the bus. Once the bus is granted, the engine moves exactly one unit: a read from the source, then a write to the destination. It then lets go of the bus, so the processor gets the bus between units.

The last channel can also treat the word found at its source as a pointer. In that case it issues a second read at that pointer and writes the result to the destination. When several channels want the bus, the lowest-numbered one is served first. Each channel steps its addresses by its own rule, counts down, and when the count runs out it disables itself, flags completion and can interrupt.

The memory side is a valid/ready handshake. The engine raises `mem_valid` and holds address, direction and write data unchanged until the memory answers with `mem_ready`. Read data is taken in the cycle in which `mem_ready` is high. The memory may stall any access for any number of cycles. Bus ownership is a separate request/grant pair, and no access starts before the grant.

Top module: `dma_indirect_engine`

## Requirements
- R1: After reset, `bus_req`, `mem_valid`, `ch_busy`, `ch_done` and `irq` are all zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into channel `cfg_ch`. The register is chosen by `cfg_sel`: 0 = source, 1 = destination, 2 = count, 3 = control. Control bit 0 is enable, bits 2:1 are the source step mode, bits 4:3 are the destination step mode, bit 5 is interrupt enable and bit 6 is indirect. Any control write clears that channel's done flag.
- R3: In direct mode, each unit is one read at the current source address followed by one write at the current destination address, and the value written equals the value read.
- R4: After each unit, each address follows its own step mode (0 or 3 = unchanged, 1 = plus one, 2 = minus one), and the count drops by one.
- R5: Once the count reaches zero after its last unit, the channel's enable (`ch_busy`) drops and its `ch_done` rises. If a channel is enabled with a count of zero, it completes without any bus access.
- R6: `irq` is high exactly while some channel has both its done flag and its interrupt enable set.
- R7: Transfers are cycle-stolen. `bus_req` is high during every access, and it drops for at least one cycle after the write of each unit.
- R8: When several channels are ready at the moment of arbitration, the lowest-numbered one moves its next unit first.
- R9: On channel 3 with indirect set, the engine reads the source, reads again at the low address bits of that word, and writes this second value to the destination.
- R10: The indirect bit has no effect on channels 0 to 2; they transfer directly.
- R11: No access starts until `bus_gnt` is seen. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel selected for the write |
| cfg_sel | input | 2 | Register selected: source, destination, count, control |
| cfg_wdata | input | 16 | Value written |
| bus_req | output | 1 | Engine asks for bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| mem_valid | output | 1 | Access presented |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| ch_busy | output | 4 | Enable bit of each channel |
| ch_done | output | 4 | Completion flag of each channel |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge. One is the final write of a channel, which clears that channel's enable and sets its done flag. The other is a register write that enables a different, lower-numbered channel. The bench waits until the last write of channel 2 is on the bus and drives the control write for channel 0 in that same cycle. It then requires both completions, the correct data from channel 0, and a bus release between the two channels. A second collision arises when a grant is withheld while two more channels are enabled. After the grant, the order of destination addresses must show the lowest-numbered waiting channel finishing all of its units before the higher one, with the held channel's remaining unit last.

// File: rtl/dma_ind_pkg.sv
package dma_ind_pkg;

  typedef enum logic [1:0] {
    STEP_KEEP  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_KEEP2 = 2'd3
  } step_t;

  localparam logic [1:0] REG_SRC = 2'd0;
  localparam logic [1:0] REG_DST = 2'd1;
  localparam logic [1:0] REG_CNT = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;

  localparam int CTL_EN  = 0;
  localparam int CTL_SST = 1;
  localparam int CTL_DST = 3;
  localparam int CTL_IE  = 5;
  localparam int CTL_IND = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GRANT,
    PH_FETCH,
    PH_DEREF,
    PH_STORE
  } phase_t;

endpackage

// File: rtl/dma_chan_reg.sv
module dma_chan_reg
  import dma_ind_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 16,
  parameter int CW      = 8,
  parameter bit HAS_IND = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          unit_done,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          ind_o,
  output logic          ie_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          req_o
);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, ie_q, done_q;
  step_t         sst_q, dst_mode_q;
  logic          unused_wr;

  assign unused_wr = ^wr_data;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a, input step_t m);
    case (m)
      STEP_UP:   return a + AW'(1);
      STEP_DOWN: return a - AW'(1);
      default:   return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      en_q       <= 1'b0;
      ie_q       <= 1'b0;
      done_q     <= 1'b0;
      sst_q      <= STEP_KEEP;
      dst_mode_q <= STEP_KEEP;
    end else begin
      if (unit_done) begin
        src_q <= advance(src_q, sst_q);
        dst_q <= advance(dst_q, dst_mode_q);
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (en_q && cnt_q == '0) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end
      if (wr_en) begin
        case (wr_sel)
          REG_SRC: src_q <= wr_data[AW-1:0];
          REG_DST: dst_q <= wr_data[AW-1:0];
          REG_CNT: cnt_q <= wr_data[CW-1:0];
          default: begin
            en_q       <= wr_data[CTL_EN];
            sst_q      <= step_t'(wr_data[CTL_SST +: 2]);
            dst_mode_q <= step_t'(wr_data[CTL_DST +: 2]);
            ie_q       <= wr_data[CTL_IE];
            done_q     <= 1'b0;
          end
        endcase
      end
    end
  end

  generate
    if (HAS_IND) begin : g_ind
      logic ind_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ind_q <= 1'b0;
        else if (wr_en && wr_sel == REG_CTL) ind_q <= wr_data[CTL_IND];
      end
      assign ind_o = ind_q;
    end else begin : g_direct
      assign ind_o = 1'b0;
    end
  endgenerate

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign ie_o   = ie_q;
  assign busy_o = en_q;
  assign done_o = done_q;
  assign req_o  = en_q && (cnt_q != '0);

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] win
);

  logic [NCH:0]   seen;
  logic [NCH-1:0] pick;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chain
      assign pick[i]   = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  always_comb begin
    win = '0;
    for (int i = 0; i < NCH; i++) begin
      win = win | (CHW'(i) & {CHW{pick[i]}});
    end
  end

  assign any = seen[NCH];

endmodule

// File: rtl/dma_indirect_engine.sv
module dma_indirect_engine
  import dma_ind_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 10,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NCH-1:0] ch_busy,
  output logic [NCH-1:0] ch_done,
  output logic           irq
);

  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [NCH-1:0] ind_v, ie_v, req_v, unit_done;

  phase_t         ph_q;
  logic [CHW-1:0] cur_q;
  logic [AW-1:0]  ptr_q;
  logic [DW-1:0]  data_q;
  logic           any_req, hs;
  logic [CHW-1:0] win;

  assign hs = mem_valid && mem_ready;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_chan_reg #(
        .AW(AW), .DW(DW), .CW(CW), .HAS_IND(i == NCH - 1)
      ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && cfg_ch == CHW'(i)),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .unit_done(unit_done[i]),
        .src_o    (src_a[i]),
        .dst_o    (dst_a[i]),
        .ind_o    (ind_v[i]),
        .ie_o     (ie_v[i]),
        .busy_o   (ch_busy[i]),
        .done_o   (ch_done[i]),
        .req_o    (req_v[i])
      );
      assign unit_done[i] = hs && (ph_q == PH_STORE) && (cur_q == CHW'(i));
    end
  endgenerate

  dma_prio_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .req(req_v),
    .any(any_req),
    .win(win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cur_q  <= '0;
      ptr_q  <= '0;
      data_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (any_req) begin
          cur_q <= win;
          ph_q  <= PH_GRANT;
        end
        PH_GRANT: if (bus_gnt) ph_q <= PH_FETCH;
        PH_FETCH: if (hs) begin
          if (ind_v[cur_q]) begin
            ptr_q <= mem_rdata[AW-1:0];
            ph_q  <= PH_DEREF;
          end else begin
            data_q <= mem_rdata;
            ph_q   <= PH_STORE;
          end
        end
        PH_DEREF: if (hs) begin
          data_q <= mem_rdata;
          ph_q   <= PH_STORE;
        end
        PH_STORE: if (hs) ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (ph_q)
      PH_FETCH: mem_addr = src_a[cur_q];
      PH_DEREF: mem_addr = ptr_q;
      PH_STORE: mem_addr = dst_a[cur_q];
      default:  mem_addr = '0;
    endcase
  end

  assign mem_valid = (ph_q == PH_FETCH) || (ph_q == PH_DEREF) || (ph_q == PH_STORE);
  assign mem_we    = (ph_q == PH_STORE);
  assign mem_wdata = data_q;
  assign bus_req   = (ph_q != PH_IDLE);
  assign irq       = |(ch_done & ie_v);

endmodule

// File: rtl/dma_ind_chk.sv
module dma_ind_chk #(
  parameter int NCH = 4,
  parameter int AW  = 10,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic [NCH-1:0] ch_busy,
  input logic [NCH-1:0] ch_done,
  input logic           irq
);

  AST_ACCESS_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req); // R7

  AST_RELEASE_AFTER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> !bus_req); // R7

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(bus_gnt)); // R11

  AST_ACCESS_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (|ch_busy)); // R3

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ch_done)); // R6

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_done
      AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_done[i]) |-> !ch_busy[i]); // R5
    end
  endgenerate

endmodule

bind dma_indirect_engine dma_ind_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .ch_busy  (ch_busy),
  .ch_done  (ch_done),
  .irq      (irq)
);

// File: tb/sim_dma_indirect_engine.sv
module sim_dma_indirect_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_req, bus_gnt = 1'b0;
  logic        mem_valid, mem_ready = 1'b0, mem_we;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [3:0]  ch_busy, ch_done;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [0:1023];
  logic [9:0]  wlog_a [0:63];
  logic [15:0] wlog_d [0:63];
  int  wn = 0, req_rises = 0, cyc = 0;
  bit  stall_en = 0, gnt_block = 0, last_req = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_indirect_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ch_busy(ch_busy), .ch_done(ch_done), .irq(irq)
  );

  assign mem_rdata = mem[mem_addr];

  function automatic logic [15:0] init_val(input int a);
    if (a < 512) return 16'((a * 13 + 7) % 400);
    return 16'(a) ^ 16'hA5A5;
  endfunction

  function automatic int step_by(input int a, input int m, input int k);
    if (m == 1) return (a + k) & 1023;
    if (m == 2) return (a - k) & 1023;
    return a;
  endfunction

  function automatic logic [15:0] ctl(input bit en, input int sm, input int dm, input bit ie, input bit ind);
    return 16'(en) | 16'(sm << 1) | 16'(dm << 3) | 16'(ie) << 5 | 16'(ind) << 6;
  endfunction

  // memory and bus model
  always @(negedge clk) begin
    cyc++;
    mem_ready = !(stall_en && (cyc % 3 == 1));
    bus_gnt   = bus_req && !gnt_block;
    if (bus_req && !last_req) req_rises++;
    last_req = bus_req;
    if (mem_valid && mem_ready && mem_we) begin
      mem[mem_addr] = mem_wdata;
      if (wn < 64) begin
        wlog_a[wn] = mem_addr;
        wlog_d[wn] = mem_wdata;
      end
      wn++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input int ch, input string req);
    int t = 0;
    while (!ch_done[ch] && t < 600) begin
      @(negedge clk);
      t++;
    end
    chk(ch_done[ch] == 1'b1, req, "completion flag", int'(ch_done[ch]), 1);
  endtask

  // run one transfer and check the write log
  task automatic run_xfer(input int ch, input int src, input int dst, input int n,
                          input int sm, input int dm, input bit ie, input bit ind);
    wn = 0;
    wr(ch, 0, 16'(src));
    wr(ch, 1, 16'(dst));
    wr(ch, 2, 16'(n));
    wr(ch, 3, ctl(1'b1, sm, dm, ie, ind));
    wait_done(ch, "R5");
    @(negedge clk);
    chk(wn == n, "R3", "unit count", wn, n);
    for (int k = 0; k < n && k < 64; k++) begin
      int s = step_by(src, sm, k);
      int d = step_by(dst, dm, k);
      int e = (ind && ch == 3) ? int'(init_val(int'(init_val(s)))) : int'(init_val(s));
      chk(int'(wlog_a[k]) == d, "R4", "destination address", int'(wlog_a[k]), d);
      chk(int'(wlog_d[k]) == e, ind ? (ch == 3 ? "R9" : "R10") : "R3", "written data", int'(wlog_d[k]), e);
    end
    chk(ch_busy[ch] == 1'b0, "R5", "enable cleared", int'(ch_busy[ch]), 0);
    chk(irq == ie, "R6", "irq with done", int'(irq), int'(ie));
    wr(ch, 3, 16'h0000);
    @(negedge clk);
    chk(ch_done[ch] == 1'b0, "R2", "control write clears done", int'(ch_done[ch]), 0);
    chk(irq == 1'b0, "R6", "irq after clear", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = init_val(a);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_req == 0, "R1", "bus_req", int'(bus_req), 0);
    chk(mem_valid == 0, "R1", "mem_valid", int'(mem_valid), 0);
    chk(ch_busy == 0, "R1", "ch_busy", int'(ch_busy), 0);
    chk(ch_done == 0, "R1", "ch_done", int'(ch_done), 0);
    chk(irq == 0, "R1", "irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5: every channel, every step mode pair, two lengths
    for (int ch = 0; ch < 4; ch++)
      for (int sm = 0; sm < 4; sm++)
        for (int dm = 0; dm < 4; dm++)
          for (int ln = 0; ln < 2; ln++) begin
            int n = ln ? 3 : 1;
            stall_en = (ln == 1);
            run_xfer(ch, 110 + ch * 40, 610 + ch * 40, n, sm, dm, ch[0], 1'b0);
          end

    // R9 indirect on channel 3, R10 indirect ignored elsewhere
    for (int sm = 0; sm < 3; sm++) begin
      stall_en = sm[0];
      run_xfer(3, 230, 700, 3, sm, 1, 1'b1, 1'b1);
      run_xfer(1, 150, 660, 3, sm, 2, 1'b0, 1'b1);
    end
    stall_en = 0;

    // R5 zero count completes without access
    wn = 0;
    wr(0, 2, 16'd0);
    wr(0, 3, ctl(1'b1, 1, 1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    chk(ch_done[0] == 1'b1, "R5", "zero count done", int'(ch_done[0]), 1);
    chk(ch_busy[0] == 1'b0, "R5", "zero count enable", int'(ch_busy[0]), 0);
    chk(wn == 0, "R5", "zero count writes", wn, 0);
    wr(0, 3, 16'h0000);

    // R8 priority and R11 grant wait
    wn = 0;
    gnt_block = 1;
    wr(3, 0, 16'd120); wr(3, 1, 16'd700); wr(3, 2, 16'd2);
    wr(3, 3, ctl(1'b1, 1, 1, 1'b0, 1'b0));
    wr(2, 0, 16'd130); wr(2, 1, 16'd720); wr(2, 2, 16'd1);
    wr(2, 3, ctl(1'b1, 1, 1, 1'b0, 1'b0));
    wr(1, 0, 16'd140); wr(1, 1, 16'd740); wr(1, 2, 16'd2);
    wr(1, 3, ctl(1'b1, 1, 1, 1'b0, 1'b0));
    chk(mem_valid == 1'b0, "R11", "no access before grant", int'(mem_valid), 0);
    chk(bus_req == 1'b1, "R7", "request raised", int'(bus_req), 1);
    req_rises = 0;
    last_req = 1;
    gnt_block = 0;
    wait_done(3, "R8");
    @(negedge clk);
    chk(wn == 5, "R8", "units in order test", wn, 5);
    chk(int'(wlog_a[0]) == 700, "R8", "first unit held channel", int'(wlog_a[0]), 700);
    chk(int'(wlog_a[1]) == 740, "R8", "lowest channel next", int'(wlog_a[1]), 740);
    chk(int'(wlog_a[2]) == 741, "R8", "lowest channel again", int'(wlog_a[2]), 741);
    chk(int'(wlog_a[3]) == 720, "R8", "middle channel", int'(wlog_a[3]), 720);
    chk(int'(wlog_a[4]) == 701, "R8", "held channel last", int'(wlog_a[4]), 701);
    chk(req_rises == 4, "R7", "bus released between units", req_rises, 4);
    for (int c = 1; c < 4; c++) wr(c, 3, 16'h0000);

    // same-cycle: channel 2 last write while channel 0 is enabled
    wn = 0;
    wr(0, 0, 16'd160); wr(0, 1, 16'd680); wr(0, 2, 16'd2);
    wr(2, 0, 16'd170); wr(2, 1, 16'd760); wr(2, 2, 16'd1);
    wr(2, 3, ctl(1'b1, 0, 0, 1'b0, 1'b0));
    @(negedge clk);
    while (!(mem_valid && mem_we)) @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'd0; cfg_sel = 2'd3; cfg_wdata = ctl(1'b1, 1, 1, 1'b1, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    wait_done(0, "R5");
    @(negedge clk);
    chk(ch_done[2] == 1'b1, "R5", "collided channel done", int'(ch_done[2]), 1);
    chk(wn == 3, "R3", "collision unit count", wn, 3);
    chk(int'(wlog_d[1]) == int'(init_val(160)), "R3", "collision data 0", int'(wlog_d[1]), int'(init_val(160)));
    chk(int'(wlog_d[2]) == int'(init_val(161)), "R4", "collision data 1", int'(wlog_d[2]), int'(init_val(161)));
    chk(irq == 1'b1, "R6", "irq from channel 0", int'(irq), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule